// File: doc/BRIEF.md
# Wrapping DMA Source Address Generator

This block holds and advances the source address of one DMA channel. A transfer engine asks for the next address through a valid/ready step port. On each accepted step the address moves up or down by the transfer unit (1, 2 or 4 bytes). A control word can confine the movement to a naturally aligned power-of-two window. Inside the window only the low address bits change and the bits above it stay fixed. When a step crosses the window edge, the low bits wrap.

A wrap can stop the channel and raise an interrupt flag. In block mode the stop waits for the beat that ends the current block. Once stopped, software re-enables the channel and it resumes from the exact address at which it halted. With no window selected, the address runs linearly over the full width and the wrap interrupt enable does nothing.

Back-pressure rules on the step port:
- `step_ready` is high exactly while the channel is enabled.
- A step is taken only on a cycle where `step_valid` and `step_ready` are both high.
- `step_valid` may be held high while `step_ready` is low. The address then stays put.
- `step_dir`, `step_size`, `block_mode` and `block_end` are sampled only on the accepting cycle.

Top module: `dwag_addr_gen`

## Requirements
- R1: The control word read back is {wrap_ie at bit 15, zeros at bits 14:13, area code at bits 12:8, zeros at bits 7:0}. Bits 14:13 ignore writes. Everything resets to 0.
- R2: Area code c from 1 to 26 selects a window of 2^(c+1) bytes (4 bytes to 128 Mbytes). Code 0 and codes 27 to 31 select plain 32-bit linear addressing, which wraps modulo 2^32 without any event.
- R3: An accepted step moves the address by 1, 2 or 4 bytes for `step_size` 0, 1 or 2 (3 acts as 4). The step is upward when `step_dir` is 0 and downward when it is 1.
- R4: While a window is active, a step never changes the address bits above the window.
- R5: A wrap is a carry or borrow out of the window's low field. On an upward wrap the low field restarts at the window start. On a downward wrap it goes to the last unit of the window (for an aligned address).
- R6: With wrap_ie=1, a window active and `block_mode` low, a wrapping step clears `chan_en` and sets `irq` on the same clock edge that stores the wrapped address.
- R7: With `block_mode` high, a wrap only arms a pending stop. The stop and the flag take effect on the edge of the accepted beat that has `block_end` high. Earlier beats keep the channel running.
- R8: Writing status bit 0 to 1 after a stop re-enables the channel. The next step continues from the halted address.
- R9: With no window active, wrap_ie has no effect: the channel keeps running and `irq` stays low.
- R10: `irq` is a sticky flag. It is cleared only by a status write with bit 1 = 0. Writing 1 to bit 1 leaves it unchanged.
- R11: `step_ready` equals `chan_en`. Without an accepted step, `src_addr` only changes on `addr_wr_en`, which loads `addr_wr_data` on the next edge.
- R12: With wrap_ie=0, a wrap still folds the address into the window and the channel keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Control word write strobe |
| cfg_wr_data | input | 16 | Control word write value |
| cfg_rd_data | output | 16 | Control word read value |
| addr_wr_en | input | 1 | Address load strobe |
| addr_wr_data | input | 32 | Address load value |
| stat_wr_en | input | 1 | Status write strobe |
| stat_wr_data | input | 2 | Bit 0 channel enable, bit 1 flag (writing 0 clears it) |
| chan_en | output | 1 | Channel enable state |
| irq | output | 1 | Wrap interrupt flag |
| step_valid | input | 1 | Step request |
| step_ready | output | 1 | Step accepted when high with step_valid |
| step_dir | input | 1 | 0 up, 1 down |
| step_size | input | 2 | 0: 1 byte, 1: 2 bytes, 2/3: 4 bytes |
| block_mode | input | 1 | Defer wrap stop to the block end |
| block_end | input | 1 | Marks the last beat of a block |
| src_addr | output | 32 | Current source address |

## Verification
Every result of this block is due one clock after the cycle that causes it:
- the stepped or loaded address,
- the cleared enable and the set flag,
- the control word readback.

`step_ready` is combinational from the enable. The bench drives each stimulus on a falling edge and holds it across one rising edge. It compares the outputs on the next falling edge against a model of window offsets. Deferred stops are checked beat by beat, so an early stop is caught in the exact cycle it appears.

// File: rtl/dwag_pkg.sv
package dwag_pkg;
  localparam int CODE_W = 5;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } xfer_size_e;

  typedef struct packed {
    logic              wrap_ie;
    logic [CODE_W-1:0] area;
  } cfg_t;
endpackage

// File: rtl/dwag_cfg_reg.sv
module dwag_cfg_reg
  import dwag_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [15:0]       wr_data,
  output logic [15:0]       rd_data,
  output logic              wrap_ie,
  output logic              win_active,
  output logic [ADDR_W-1:0] win_mask
);
  localparam int MAX_CODE = ADDR_W - 6;

  cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (wr_en) begin
      cfg_q.wrap_ie <= wr_data[15];
      cfg_q.area    <= wr_data[12:8];
    end
  end

  logic unused_wr_bits;
  assign unused_wr_bits = ^{wr_data[14:13], wr_data[7:0]};

  assign rd_data    = {cfg_q.wrap_ie, 2'b00, cfg_q.area, 8'h00};
  assign wrap_ie    = cfg_q.wrap_ie;
  assign win_active = (cfg_q.area != '0) && (int'(cfg_q.area) <= MAX_CODE);

  // Bit g is inside the window when g <= code (window = 2^(code+1) bytes).
  for (genvar g = 0; g < ADDR_W; g++) begin : g_mask
    assign win_mask[g] = ~win_active | (g <= int'(cfg_q.area));
  end
endmodule

// File: rtl/dwag_stepper.sv
module dwag_stepper
  import dwag_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] mask,
  input  logic              win_active,
  input  logic              dir_down,
  input  logic [1:0]        size,
  output logic [ADDR_W-1:0] next_addr,
  output logic              wrapped
);
  logic [ADDR_W:0] low_x, step_x, res_x;

  always_comb begin
    unique case (xfer_size_e'(size))
      SZ_BYTE: step_x = (ADDR_W+1)'(1);
      SZ_HALF: step_x = (ADDR_W+1)'(2);
      default: step_x = (ADDR_W+1)'(4);
    endcase
    low_x = {1'b0, addr & mask};
    res_x = dir_down ? (low_x - step_x) : (low_x + step_x);
    // A carry lands above the mask; a borrow propagates to the top bit.
    wrapped = win_active &
              (dir_down ? res_x[ADDR_W] : (|(res_x & ~{1'b0, mask})));
    next_addr = (addr & ~mask) | (res_x[ADDR_W-1:0] & mask);
  end
endmodule

// File: rtl/dwag_chan_ctl.sv
module dwag_chan_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic wrapped,
  input  logic ie_eff,
  input  logic block_mode,
  input  logic block_end,
  input  logic sw_wr,
  input  logic sw_en,
  input  logic sw_flag,
  output logic chan_en,
  output logic flag
);
  logic en_q, flag_q, pend_q;
  logic ovf_ev, stop;

  always_comb begin
    ovf_ev = fire & wrapped & ie_eff;
    if (block_mode) stop = fire & block_end & (pend_q | ovf_ev);
    else            stop = ovf_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      flag_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (stop)       en_q <= 1'b0;
      else if (sw_wr) en_q <= sw_en;

      if (stop)                  flag_q <= 1'b1;
      else if (sw_wr && !sw_flag) flag_q <= 1'b0;

      if (stop)                      pend_q <= 1'b0;
      else if (ovf_ev && block_mode) pend_q <= 1'b1;
    end
  end

  assign chan_en = en_q;
  assign flag    = flag_q;
endmodule

// File: rtl/dwag_addr_gen.sv
module dwag_addr_gen
  import dwag_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [15:0]       cfg_wr_data,
  output logic [15:0]       cfg_rd_data,
  input  logic              addr_wr_en,
  input  logic [ADDR_W-1:0] addr_wr_data,
  input  logic              stat_wr_en,
  input  logic [1:0]        stat_wr_data,
  output logic              chan_en,
  output logic              irq,
  input  logic              step_valid,
  output logic              step_ready,
  input  logic              step_dir,
  input  logic [1:0]        step_size,
  input  logic              block_mode,
  input  logic              block_end,
  output logic [ADDR_W-1:0] src_addr
);
  logic              wrap_ie, win_active, wrapped, fire;
  logic [ADDR_W-1:0] win_mask, next_addr, addr_q;

  dwag_cfg_reg #(.ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
    .rd_data(cfg_rd_data), .wrap_ie(wrap_ie), .win_active(win_active),
    .win_mask(win_mask)
  );

  dwag_stepper #(.ADDR_W(ADDR_W)) u_step (
    .addr(addr_q), .mask(win_mask), .win_active(win_active),
    .dir_down(step_dir), .size(step_size), .next_addr(next_addr),
    .wrapped(wrapped)
  );

  dwag_chan_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .fire(fire), .wrapped(wrapped),
    .ie_eff(wrap_ie & win_active), .block_mode(block_mode),
    .block_end(block_end), .sw_wr(stat_wr_en), .sw_en(stat_wr_data[0]),
    .sw_flag(stat_wr_data[1]), .chan_en(chan_en), .flag(irq)
  );

  assign step_ready = chan_en;
  assign fire       = step_valid & chan_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          addr_q <= '0;
    else if (addr_wr_en) addr_q <= addr_wr_data;
    else if (fire)       addr_q <= next_addr;
  end

  assign src_addr = addr_q;
endmodule

// File: rtl/dwag_checker.sv
module dwag_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr_en,
  input logic [15:0]       cfg_rd_data,
  input logic              addr_wr_en,
  input logic              stat_wr_en,
  input logic [1:0]        stat_wr_data,
  input logic              chan_en,
  input logic              irq,
  input logic              step_valid,
  input logic              step_ready,
  input logic [ADDR_W-1:0] src_addr
);
  localparam int MAX_CODE = ADDR_W - 6;

  logic [4:0]        code;
  logic              active, fire;
  logic [ADDR_W-1:0] mask;

  always_comb begin
    code   = cfg_rd_data[12:8];
    active = (code != 0) && (int'(code) <= MAX_CODE);
    for (int i = 0; i < ADDR_W; i++) mask[i] = !active || (i <= int'(code));
    fire = step_valid && step_ready;
  end

  // R11: no step and no load keeps the address
  assert_hold_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !addr_wr_en) |=> $stable(src_addr));

  // R4: bits above the window are untouched by a step
  assert_upper_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !addr_wr_en && !cfg_wr_en) |=>
      (((src_addr ^ $past(src_addr)) & ~$past(mask)) == '0));

  // R6: the flag rises only together with a stopped channel
  assert_stop_with_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !chan_en);

  // R9: no window, no interrupt
  assert_no_window_no_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !$rose(irq));

  // R10: flag stays until software writes 0 to it
  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(stat_wr_en && !stat_wr_data[1])) |=> irq);
endmodule

bind dwag_addr_gen dwag_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_rd_data(cfg_rd_data),
  .addr_wr_en(addr_wr_en), .stat_wr_en(stat_wr_en),
  .stat_wr_data(stat_wr_data), .chan_en(chan_en), .irq(irq),
  .step_valid(step_valid), .step_ready(step_ready), .src_addr(src_addr)
);

// File: tb/dwag_addr_gen_tb.sv
`timescale 1ns/1ps
module dwag_addr_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [15:0] cfg_wr_data = '0;
  logic [15:0] cfg_rd_data;
  logic        addr_wr_en = 1'b0;
  logic [31:0] addr_wr_data = '0;
  logic        stat_wr_en = 1'b0;
  logic [1:0]  stat_wr_data = '0;
  logic        chan_en, irq, step_ready;
  logic        step_valid = 1'b0;
  logic        step_dir = 1'b0;
  logic [1:0]  step_size = '0;
  logic        block_mode = 1'b0;
  logic        block_end = 1'b0;
  logic [31:0] src_addr;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dwag_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .addr_wr_en(addr_wr_en),
    .addr_wr_data(addr_wr_data), .stat_wr_en(stat_wr_en),
    .stat_wr_data(stat_wr_data), .chan_en(chan_en), .irq(irq),
    .step_valid(step_valid), .step_ready(step_ready), .step_dir(step_dir),
    .step_size(step_size), .block_mode(block_mode), .block_end(block_end),
    .src_addr(src_addr)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Model: {wrap, next address} from window offset arithmetic
  function automatic logic [32:0] model(input logic [31:0] a, input int code,
                                        input bit dn, input int sz);
    longint unsigned w, off, base, s;
    bit ov;
    s = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    if (code >= 1 && code <= 26) begin
      w = 64'd1 << (code + 1);
      off = {32'd0, a} % w;
      base = {32'd0, a} - off;
      if (!dn) begin
        off += s; ov = (off >= w); if (ov) off -= w;
      end else begin
        ov = (off < s); off = ov ? off + w - s : off - s;
      end
      return {ov, 32'(base + off)};
    end
    return {1'b0, dn ? a - 32'(s) : a + 32'(s)};
  endfunction

  task automatic wr_cfg(input bit ie, input int code);
    cfg_wr_en = 1; cfg_wr_data = {ie, 2'b11, 5'(code), 8'hA5};
    @(negedge clk); cfg_wr_en = 0;
  endtask

  task automatic wr_addr(input logic [31:0] a);
    addr_wr_en = 1; addr_wr_data = a;
    @(negedge clk); addr_wr_en = 0;
  endtask

  task automatic wr_stat(input bit fl, input bit en);
    stat_wr_en = 1; stat_wr_data = {fl, en};
    @(negedge clk); stat_wr_en = 0;
  endtask

  task automatic step(input bit dn, input int sz, input bit bm, input bit be);
    step_valid = 1; step_dir = dn; step_size = 2'(sz);
    block_mode = bm; block_end = be;
    @(negedge clk);
    step_valid = 0; block_mode = 0; block_end = 0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] a;
    logic [32:0] m;
    int codes [8] = '{1, 2, 3, 5, 8, 26, 0, 29};
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 R11: reset state
    check(cfg_rd_data == 16'h0, "R1 reset cfg", {16'h0, cfg_rd_data}, 0);
    check(src_addr == 0 && !chan_en && !irq && !step_ready, "R11 reset",
          src_addr, 0);
    // R1: field layout, reserved bits read 0
    wr_cfg(1, 31);
    check(cfg_rd_data == 16'h9F00, "R1 layout", {16'h0, cfg_rd_data}, 32'h9F00);
    // R11: disabled channel ignores step_valid
    wr_addr(32'h0000_1000);
    step(0, 2, 0, 0);
    check(src_addr == 32'h1000, "R11 not ready", src_addr, 32'h1000);
    check(step_ready == 0, "R11 ready low", {31'd0, step_ready}, 0);

    // R12 R3 R4 R5: random walk with wrap_ie=0
    wr_cfg(0, 1);
    wr_stat(0, 1);
    for (int it = 0; it < 300; it++) begin
      int code, sz;
      code = codes[$urandom_range(7)];
      wr_cfg(0, code);
      sz = $urandom_range(3);
      a = $urandom();
      a = a & ~32'(((sz == 0) ? 1 : (sz == 1) ? 2 : 4) - 1);
      wr_addr(a);
      for (int k = 0; k < 6; k++) begin
        bit dn;
        dn = 1'($urandom_range(1));
        m = model(a, code, dn, sz);
        step(dn, sz, 0, 0);
        check(src_addr == m[31:0], "R3 R4 R5 step", src_addr, m[31:0]);
        check(chan_en == 1, "R12 keeps running", {31'd0, chan_en}, 1);
        a = m[31:0];
      end
    end

    // R6 R5: up wrap in 8-byte window stops channel
    wr_cfg(1, 2);
    wr_addr(32'h1234_5676);
    step(0, 1, 0, 0);
    check(src_addr == 32'h1234_5670, "R5 up wrap", src_addr, 32'h1234_5670);
    check(!chan_en && irq, "R6 stop+flag", {30'd0, chan_en, irq}, 1);
    step(0, 1, 0, 0);
    check(src_addr == 32'h1234_5670, "R8 held while stopped", src_addr, 32'h1234_5670);
    // R10: writing 1 to flag keeps it; R8: resume in place
    wr_stat(1, 1);
    check(irq == 1, "R10 write1 no effect", {31'd0, irq}, 1);
    step(0, 1, 0, 0);
    check(src_addr == 32'h1234_5672 && chan_en, "R8 resume", src_addr, 32'h1234_5672);
    wr_stat(0, 1);
    check(irq == 0, "R10 clear", {31'd0, irq}, 0);

    // R5 R6: down wrap in 16-byte window
    wr_cfg(1, 3);
    wr_addr(32'hABCD_0000);
    step(1, 2, 0, 0);
    check(src_addr == 32'hABCD_000C, "R5 down wrap", src_addr, 32'hABCD_000C);
    check(!chan_en && irq, "R6 down stop", {30'd0, chan_en, irq}, 1);
    wr_stat(0, 1);

    // R7: block mode defers stop to block end
    wr_cfg(1, 1);
    wr_addr(32'h0000_0100);
    step(0, 1, 1, 0);
    check(src_addr == 32'h102 && chan_en, "R7 beat1", src_addr, 32'h102);
    step(0, 1, 1, 0);
    check(src_addr == 32'h100 && chan_en && !irq, "R7 wrap deferred", src_addr, 32'h100);
    step(0, 1, 1, 0);
    check(src_addr == 32'h102 && chan_en && !irq, "R7 still running", src_addr, 32'h102);
    step(0, 1, 1, 1);
    check(src_addr == 32'h100 && !chan_en && irq, "R7 stop at end", src_addr, 32'h100);
    wr_stat(0, 1);
    step(0, 1, 1, 1);
    check(src_addr == 32'h102 && chan_en && !irq, "R8 R7 resume no stale",
          src_addr, 32'h102);

    // R9 R2: no window, ie=1 has no effect
    wr_cfg(1, 0);
    wr_addr(32'hFFFF_FFFC);
    step(0, 2, 0, 0);
    check(src_addr == 32'h0 && chan_en && !irq, "R9 R2 code0", src_addr, 0);
    wr_cfg(1, 27);
    step(1, 0, 0, 0);
    check(src_addr == 32'hFFFF_FFFF && chan_en && !irq, "R9 R2 code27",
          src_addr, 32'hFFFF_FFFF);
    // R2: largest window 128 MB
    wr_cfg(0, 26);
    wr_addr(32'h37FF_FFFE);
    step(0, 1, 0, 0);
    check(src_addr == 32'h3000_0000, "R2 code26", src_addr, 32'h3000_0000);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule